// File: doc/BRIEF.md
# Blanked PWM Pulse Generator

This block is a fixed-frequency digital pulse-width modulator core. A free-running counter divides time into periods of a programmable length. Each period opens with a forced dead-time phase, in which both gate outputs are held low, and then moves to a ramp phase. A gate pulse starts on the first clock of the ramp phase. It ends at the first of three events: the ramp reaching the control level, a current-limit flag, or an overcurrent kill input. Once a pulse has ended it stays low until the next period starts.

The ramp is either the count of clocks since the dead time ended, or an external sample supplied every clock. A leading-edge blanking window of a programmable number of clocks at the start of each ramp phase hides the ramp compare and the current-limit flag, so that switching noise cannot cut a pulse short. The overcurrent kill is never hidden. In in-phase mode both gates fire in every period. In alternating mode a toggle steers each period's pulse to one gate only, so each gate switches at half the period rate.

The comparators and the drivers lie outside the block. Their results arrive as bits synchronous to the clock.

Top module: `pwm_blank_core`

## Requirements
- R1: While `rstN` is low, both outputs are low, the period counter is at the start of dead time, and the alternating toggle points at `outA`. The first period after release is steered to `outA`.
- R2: A period lasts `periodLen` clocks. Its first `deadLen` clocks are dead time, and both outputs are low during dead time. A `deadLen` of 0 acts as 1.
- R3: Without a terminator, a pulse rises on the first clock after dead time and lasts to the end of the period.
- R4: The ramp value is the number of clocks since dead time ended, starting at 0, or `rampExt` when `useExtRamp` is 1. The pulse ends in the same clock in which the ramp value is greater than or equal to `ctrlLevel` (unsigned). With `ctrlLevel` 0 and no blanking, the duty is 0.
- R5: During the first `blankLen` clocks of the ramp phase, the ramp compare is ignored. A `blankLen` of 0 disables blanking.
- R6: `curLimit` is ignored during blanking. After blanking, `curLimit` ends the pulse in the same clock.
- R7: An ended pulse stays low for the rest of the period, even after the terminating condition clears.
- R8: `overCur` is never blanked. It drives both outputs low in the same clock in which it is high, and it ends the pulse for the rest of the period.
- R9: With `altMode` 0, `outA` and `outB` are identical in every clock.
- R10: With `altMode` 1, only the gate selected by the toggle may pulse. The toggle flips at every period boundary, so the two gates take turns, period by period, and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| periodLen | input | CNT_W | Period length in clocks |
| deadLen | input | CNT_W | Dead-time length in clocks (0 acts as 1) |
| ctrlLevel | input | CNT_W | Control level for the ramp compare |
| rampExt | input | CNT_W | External ramp sample |
| useExtRamp | input | 1 | 1 selects `rampExt`, 0 selects the internal ramp |
| blankLen | input | BLANK_W | Blanking window in clocks (0 disables blanking) |
| curLimit | input | 1 | Current-limit flag, blankable |
| overCur | input | 1 | Overcurrent kill, never blanked |
| altMode | input | 1 | 0 selects in-phase mode, 1 selects alternating mode |
| outA | output | 1 | Gate output A |
| outB | output | 1 | Gate output B |

## Verification
The checker enforces four properties on every clock. Both gates are low in dead time. Overcurrent forces both gates low in the same clock. The gates are equal in in-phase mode and never high together in alternating mode. A gate that went low inside a ramp phase does not rise again before the period ends. Other behaviour can only be shown by the bench's scenarios. These cover the exact clock on which a pulse starts and ends for a given control level, the length of the blanking window for both the ramp compare and the current limit, a zero dead-time setting, the external ramp, and the toggle returning to gate A after a reset. The bench checks each of these against a cycle model built from the requirements.

// File: rtl/pwm_blank_pkg.sv
package pwm_blank_pkg;
  // Strobes passed from the timebase to the gate control each clock
  typedef struct packed {
    logic deadPh;     // current clock is in the dead-time phase
    logic periodEnd;  // current clock is the last of the period
    logic blankPh;    // current clock is inside the blanking window
    logic pwmHit;     // ramp value has reached the control level
  } tick_t;
endpackage

// File: rtl/pwm_blank_timebase.sv
module pwm_blank_timebase
  import pwm_blank_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int BLANK_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [CNT_W-1:0]   periodLen,
  input  logic [CNT_W-1:0]   deadLen,
  input  logic [CNT_W-1:0]   ctrlLevel,
  input  logic [CNT_W-1:0]   rampExt,
  input  logic               useExtRamp,
  input  logic [BLANK_W-1:0] blankLen,
  output tick_t              tick
);
  localparam int EXT_W = CNT_W + 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] effDead;
  logic [CNT_W-1:0] rampIdx;
  logic [CNT_W-1:0] rampVal;
  logic [CNT_W-1:0] blankExt;

  always_comb begin
    effDead   = (deadLen == '0) ? CNT_W'(1) : deadLen;
    blankExt  = CNT_W'(blankLen);
    rampIdx   = cnt - effDead;
    rampVal   = useExtRamp ? rampExt : rampIdx;
    tick.deadPh    = cnt < effDead;
    tick.periodEnd = (EXT_W'(cnt) + EXT_W'(1)) >= EXT_W'(periodLen);
    tick.pwmHit    = rampVal >= ctrlLevel;
    tick.blankPh   = !tick.deadPh && (rampIdx < blankExt);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               cnt <= '0;
    else if (tick.periodEnd) cnt <= '0;
    else                     cnt <= cnt + CNT_W'(1);
  end
endmodule

// File: rtl/pwm_blank_gate.sv
module pwm_blank_gate
  import pwm_blank_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  tick_t tick,
  input  logic  curLimit,
  input  logic  overCur,
  input  logic  altMode,
  output logic  outA,
  output logic  outB
);
  logic killed;   // pulse already ended in this period
  logic steerB;   // toggle: 0 steers to A, 1 steers to B
  logic termNow;
  logic pulse;

  always_comb begin
    termNow = overCur | (!tick.blankPh & (tick.pwmHit | curLimit));
    pulse   = !tick.deadPh & !killed & !termNow;
    outA    = pulse & (!altMode | !steerB);
    outB    = pulse & (!altMode |  steerB);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      killed <= 1'b0;
      steerB <= 1'b0;
    end else if (tick.periodEnd) begin
      killed <= 1'b0;
      steerB <= ~steerB;
    end else if (!tick.deadPh && termNow) begin
      killed <= 1'b1;
    end
  end
endmodule

// File: rtl/pwm_blank_core.sv
module pwm_blank_core
  import pwm_blank_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int BLANK_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [CNT_W-1:0]   periodLen,
  input  logic [CNT_W-1:0]   deadLen,
  input  logic [CNT_W-1:0]   ctrlLevel,
  input  logic [CNT_W-1:0]   rampExt,
  input  logic               useExtRamp,
  input  logic [BLANK_W-1:0] blankLen,
  input  logic               curLimit,
  input  logic               overCur,
  input  logic               altMode,
  output logic               outA,
  output logic               outB
);
  tick_t tick;

  pwm_blank_timebase #(.CNT_W(CNT_W), .BLANK_W(BLANK_W)) timebaseI (
    .clk(clk), .rstN(rstN), .periodLen(periodLen), .deadLen(deadLen),
    .ctrlLevel(ctrlLevel), .rampExt(rampExt), .useExtRamp(useExtRamp),
    .blankLen(blankLen), .tick(tick)
  );

  pwm_blank_gate gateI (
    .clk(clk), .rstN(rstN), .tick(tick), .curLimit(curLimit),
    .overCur(overCur), .altMode(altMode), .outA(outA), .outB(outB)
  );
endmodule

// File: rtl/pwm_blank_chk.sv
module pwm_blank_chk
  import pwm_blank_pkg::*;
(
  input logic  clk,
  input logic  rstN,
  input logic  outA,
  input logic  outB,
  input logic  altMode,
  input logic  overCur,
  input tick_t tick
);
  // R2: dead time keeps both gates low
  a_r2_dead_low: assert property (@(posedge clk) disable iff (!rstN)
    tick.deadPh |-> (!outA && !outB));

  // R8: the overcurrent kill has no blanking
  a_r8_overcur_low: assert property (@(posedge clk) disable iff (!rstN)
    overCur |-> (!outA && !outB));

  // R9: the in-phase gates match
  a_r9_inphase_equal: assert property (@(posedge clk) disable iff (!rstN)
    !altMode |-> (outA == outB));

  // R10: the alternating gates are exclusive
  a_r10_alt_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    altMode |-> !(outA && outB));

  // R7: no re-fire inside the same ramp phase
  a_r7_no_refire: assert property (@(posedge clk) disable iff (!rstN)
    (!tick.deadPh && $past(!tick.deadPh) && $past(!(outA || outB)))
      |-> !(outA || outB));
endmodule

bind pwm_blank_core pwm_blank_chk chkI (
  .clk(clk), .rstN(rstN), .outA(outA), .outB(outB),
  .altMode(altMode), .overCur(overCur), .tick(tick)
);

// File: tb/pwm_blank_core_tb_top.sv
`timescale 1ns/1ps
module pwm_blank_core_tb_top;
  localparam int CNT_W   = 8;
  localparam int BLANK_W = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [CNT_W-1:0]   periodLen = 8'd16;
  logic [CNT_W-1:0]   deadLen   = 8'd4;
  logic [CNT_W-1:0]   ctrlLevel = 8'd5;
  logic [CNT_W-1:0]   rampExt   = '0;
  logic               useExtRamp = 1'b0;
  logic [BLANK_W-1:0] blankLen  = '0;
  logic curLimit = 1'b0, overCur = 1'b0, altMode = 1'b0;
  logic outA, outB;

  always #2 clk = ~clk;

  pwm_blank_core #(.CNT_W(CNT_W), .BLANK_W(BLANK_W)) dut_i (
    .clk(clk), .rstN(rstN), .periodLen(periodLen), .deadLen(deadLen),
    .ctrlLevel(ctrlLevel), .rampExt(rampExt), .useExtRamp(useExtRamp),
    .blankLen(blankLen), .curLimit(curLimit), .overCur(overCur),
    .altMode(altMode), .outA(outA), .outB(outB)
  );

  typedef struct {
    logic  a;
    logic  b;
    string tag;
  } exp_t;
  exp_t expQ[$];

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 1'b0;

  // Reference state, derived from the requirements
  int  mPos;       // clock index within the period
  bit  mSteerB;    // which gate the next pulse goes to
  bit  mEnded;     // pulse ended in this period

  task automatic modelReset();
    mPos = 0; mSteerB = 1'b0; mEnded = 1'b0;
  endtask

  // Driver: predict this clock's outputs, then advance the model over the next edge
  task automatic runCycles(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      exp_t e;
      int dead, rIdx, rampV;
      bit inDead, blanked, stop, on;
      if (!rstN) modelReset();
      dead    = (deadLen == 0) ? 1 : int'(deadLen);
      inDead  = mPos < dead;
      rIdx    = mPos - dead;
      rampV   = useExtRamp ? int'(rampExt) : rIdx;
      blanked = !inDead && (rIdx < int'(blankLen));
      stop    = overCur || (!blanked && ((rampV >= int'(ctrlLevel)) || curLimit));
      on      = !inDead && !mEnded && !stop;
      e.a   = on && (!altMode || !mSteerB);
      e.b   = on && (!altMode || mSteerB);
      e.tag = tag;
      expQ.push_back(e);
      if (rstN) begin
        if (mPos + 1 >= int'(periodLen)) begin
          mPos = 0; mSteerB = !mSteerB; mEnded = 1'b0;
        end else begin
          if (!inDead && stop) mEnded = 1'b1;
          mPos = mPos + 1;
        end
      end
      @(posedge clk); #1;
    end
  endtask

  task automatic alignTo(input int pos);
    while (mPos != pos) runCycles(1, "R2");
  endtask

  // Monitor: compare the outputs at the falling edge
  always @(negedge clk) begin
    exp_t e;
    if (expQ.size() > 0) begin
      e = expQ.pop_front();
      nChecks++;
      if (outA !== e.a || outB !== e.b) begin
        nFail++;
        $display("FAIL %s: outA/outB got %b%b expected %b%b at %0t",
                 e.tag, outA, outB, e.a, e.b, $time);
      end
    end
  end

  initial begin
    modelReset();
    @(posedge clk); #1;
    runCycles(3, "R1 reset");
    rstN = 1'b1;

    // R3 R4 R9: in-phase pulses that end at the control level
    runCycles(32, "R3/R4/R9");
    // R5: blanking hides a compare that would fire at once
    ctrlLevel = 8'd0; blankLen = 4'd3;
    runCycles(32, "R5 blank");
    // R4: zero control level with no blanking gives zero duty
    blankLen = 4'd0;
    runCycles(16, "R4 zero duty");
    // R6: current limit held high is hidden only while blanked
    ctrlLevel = 8'd200; blankLen = 4'd3; curLimit = 1'b1;
    runCycles(32, "R6 curlimit");
    curLimit = 1'b0; blankLen = 4'd0;
    // R7: one-clock current limit mid-ramp, then no re-fire
    alignTo(8);
    curLimit = 1'b1; runCycles(1, "R7 cut");
    curLimit = 1'b0; runCycles(20, "R7 sticky");
    // R8: overcurrent inside the blanking window
    ctrlLevel = 8'd0; blankLen = 4'd5;
    alignTo(5);
    overCur = 1'b1; runCycles(1, "R8 kill");
    overCur = 1'b0; runCycles(20, "R8 after");
    // R1 R10: reset mid-run, then alternate starting at A
    rstN = 1'b0; runCycles(2, "R1 reset");
    rstN = 1'b1;
    altMode = 1'b1; ctrlLevel = 8'd6; blankLen = 4'd0;
    runCycles(48, "R1/R10 alternate");
    altMode = 1'b0;
    // R4: external ramp at and below the control level
    alignTo(0);
    useExtRamp = 1'b1; rampExt = 8'd3; ctrlLevel = 8'd3;
    runCycles(16, "R4 ext hit");
    ctrlLevel = 8'd9;
    runCycles(16, "R4 ext below");
    useExtRamp = 1'b0;
    // R2: zero dead-time setting acts as one clock
    deadLen = 8'd0; ctrlLevel = 8'd200;
    alignTo(0);
    runCycles(32, "R2 dead zero");

    @(negedge clk); #1;
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end
endmodule